// File: doc/BRIEF.md
# Low-Power Tail Chip-Select Generator

This block drives the active-low chip-select strobe for memory bus cycles. It runs on the undivided master clock while the processor clock is divided down from it. A bus cycle takes two processor clocks plus one processor clock for each wait state, so its length in master clocks is (2 + waits) × divide ratio. A cycle-start pulse loads a down-counter with that length. The cycle ends when the counter runs out.

In normal mode the chip select is low for the whole cycle. In short mode it stays high until the last two master clocks of the cycle. Some memories draw current for as long as they are selected, so this reduces the memory duty cycle. Short mode takes effect only when the divide ratio is 4, 6 or 8. At every other ratio the block acts as in normal mode. A suppress input blocks the chip select for a whole cycle, which covers the stack write that follows an I/O access. A read cycle produces a one-clock data-capture strobe on its last clock. Every cycle produces a done pulse one clock after its last clock.

Top module: `lpcs_strobe_gen`

## Requirements
- R1: After reset `csN` is 1, `capStb` is 0, `done` is 0 and the block is idle. While idle, `csN` stays 1.
- R2: A cycle accepted on clock edge E0 lasts L = (2 + `waitCnt`) × `divRatio` master clocks, namely the clocks after edges E0 … E(L-1). In normal mode (`shortEn` = 0) `csN` is 0 on all L of them and 1 afterwards.
- R3: With `shortEn` = 1 and `divRatio` equal to 4, 6 or 8, `csN` is 0 only on the last two clocks of the cycle, after edges E(L-2) and E(L-1).
- R4: With `shortEn` = 1 and any other `divRatio`, the cycle behaves exactly as in normal mode.
- R5: `csN` stays 1 for the whole of a cycle that was started while `suppress` was 1.
- R6: `capStb` is 1 for exactly one clock, the last clock of a read cycle (`isRead` = 1). It stays 0 throughout write cycles.
- R7: `done` is 1 for exactly one clock, the clock after the last clock of the cycle.
- R8: `cycStart` is ignored while a cycle is running. A new cycle is accepted only on an edge where the block is idle.
- R9: `divRatio`, `waitCnt`, `shortEn`, `isRead` and `suppress` are sampled only at cycle start. Changing them during a cycle has no effect on that cycle.
- R10: A `divRatio` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divRatio | input | DIV_W (4) | Processor clock divide ratio |
| shortEn | input | 1 | 0 = normal chip select, 1 = short tail chip select |
| cycStart | input | 1 | Request to begin a bus cycle |
| isRead | input | 1 | 1 = read cycle, 0 = write cycle |
| waitCnt | input | WS_W (3) | Number of wait states |
| suppress | input | 1 | Block chip select for this cycle |
| csN | output | 1 | Registered active-low chip select |
| capStb | output | 1 | Data-capture strobe |
| done | output | 1 | Cycle-complete pulse |

## Verification
On every cycle the assertions check that chip select stays high while the block is idle, while a suppressed cycle runs, and in short mode while more than two clocks remain. They also check that the counter steps down by one and the sampled settings stay fixed while the counter is busy, that a start is never taken mid-cycle, that done follows the last clock, and that the capture strobe appears only on the last clock of a read. The exact cycle length and the count and placement of the chip-select low clocks can only be shown by the bench's scenarios. The same holds for the fallback to normal mode at other ratios, for a ratio of 0, and for mid-cycle input changes having no effect. The bench measures these end to end at the ports.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;
    logic dec;
  } ctlStb_t;

  // per-cycle settings captured at start
  typedef struct packed {
    logic shortOn;
    logic rd;
    logic sup;
  } cycCfg_t;
endpackage

// File: rtl/lpcs_dp.sv
module lpcs_dp
  import lpcs_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int WS_W  = 3,
  localparam int CNT_W = DIV_W + WS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             shortEn,
  input  logic             isRead,
  input  logic             suppress,
  input  logic [WS_W-1:0]  waitCnt,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cntNext,
  output cycCfg_t          cfgQ,
  output cycCfg_t          cfgNext
);
  logic [DIV_W-1:0] effDiv;
  logic [CNT_W-1:0] cycLen;
  logic             ratioOk;

  always_comb begin
    effDiv  = (divRatio == '0) ? DIV_W'(1) : divRatio;
    cycLen  = (CNT_W'(waitCnt) + CNT_W'(2)) * CNT_W'(effDiv);
    ratioOk = (divRatio == DIV_W'(4)) || (divRatio == DIV_W'(6)) ||
              (divRatio == DIV_W'(8));
  end

  always_comb begin
    if (stb.load) begin
      cntNext = cycLen;
      cfgNext = '{shortOn: shortEn && ratioOk, rd: isRead, sup: suppress};
    end else begin
      cntNext = stb.dec ? cntQ - CNT_W'(1) : cntQ;
      cfgNext = cfgQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      cfgQ <= '0;
    end else begin
      cntQ <= cntNext;
      cfgQ <= cfgNext;
    end
  end

  // R2: a running count steps down by exactly one each clock
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R9: captured settings hold for the whole cycle
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) |=> $stable(cfgQ));
endmodule

// File: rtl/lpcs_ctrl.sv
module lpcs_ctrl
  import lpcs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycStart,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] cntNext,
  input  cycCfg_t          cfgQ,
  input  cycCfg_t          cfgNext,
  output ctlStb_t          stb,
  output logic             csN,
  output logic             capStb,
  output logic             done
);
  logic idle;
  logic csOnNext;

  always_comb begin
    idle     = (cntQ == '0);
    stb.load = cycStart && idle;
    stb.dec  = !idle;
    csOnNext = (cntNext != '0) && !cfgNext.sup &&
               (!cfgNext.shortOn || (cntNext <= CNT_W'(2)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN    <= 1'b1;
      capStb <= 1'b0;
      done   <= 1'b0;
    end else begin
      csN    <= !csOnNext;
      capStb <= (cntNext == CNT_W'(1)) && cfgNext.rd;
      done   <= (cntQ == CNT_W'(1));
    end
  end

  // R1: chip select stays off whenever no cycle runs
  p_idle_cs_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0) |-> csN);

  // R5: suppressed cycle never selects memory
  p_suppress_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.sup |-> csN);

  // R3: short mode holds select off until the final two clocks
  p_short_tail_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.shortOn && (cntQ > CNT_W'(2))) |-> csN);

  // R7: done follows the last cycle clock
  p_done_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_W'(1)) |=> done);

  // R6: capture only on the last clock of a read
  p_cap_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    capStb |-> (cfgQ.rd && (cntQ == CNT_W'(1))));

  // R8: no load while busy
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) |-> !stb.load);
endmodule

// File: rtl/lpcs_strobe_gen.sv
module lpcs_strobe_gen
  import lpcs_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int WS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             shortEn,
  input  logic             cycStart,
  input  logic             isRead,
  input  logic [WS_W-1:0]  waitCnt,
  input  logic             suppress,
  output logic             csN,
  output logic             capStb,
  output logic             done
);
  localparam int CNT_W = DIV_W + WS_W + 1;

  ctlStb_t          stb;
  cycCfg_t          cfgQ, cfgNext;
  logic [CNT_W-1:0] cntQ, cntNext;

  lpcs_dp #(.DIV_W(DIV_W), .WS_W(WS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .divRatio(divRatio),
    .shortEn(shortEn), .isRead(isRead), .suppress(suppress),
    .waitCnt(waitCnt), .cntQ(cntQ), .cntNext(cntNext),
    .cfgQ(cfgQ), .cfgNext(cfgNext)
  );

  lpcs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cntQ(cntQ),
    .cntNext(cntNext), .cfgQ(cfgQ), .cfgNext(cfgNext), .stb(stb),
    .csN(csN), .capStb(capStb), .done(done)
  );
endmodule

// File: tb/test_lpcs_strobe_gen.sv
module test_lpcs_strobe_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] divRatio = '0;
  logic       shortEn = 1'b0;
  logic       cycStart = 1'b0;
  logic       isRead = 1'b0;
  logic [2:0] waitCnt = '0;
  logic       suppress = 1'b0;
  logic       csN, capStb, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpcs_strobe_gen i_lpcs_strobe_gen (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .shortEn(shortEn),
    .cycStart(cycStart), .isRead(isRead), .waitCnt(waitCnt),
    .suppress(suppress), .csN(csN), .capStb(capStb), .done(done)
  );

  function automatic int expLen(input int d, input int w);
    return (2 + w) * ((d == 0) ? 1 : d);
  endfunction

  function automatic bit expShort(input bit s, input int d);
    return s && (d == 4 || d == 6 || d == 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one bus cycle; optionally hold start and scramble inputs mid-cycle
  task automatic runCycle(input int d, input int w, input bit s, input bit rd,
                          input bit sup, input bit disturb, input string req);
    int  len = expLen(d, w);
    bit  sh = expShort(s, d);
    int  lowCnt = 0, lowBad = 0, capCnt = 0, capPos = 0, donePos = 0, doneCnt = 0;
    @(negedge clk);
    divRatio = 4'(d); waitCnt = 3'(w); shortEn = s; isRead = rd;
    suppress = sup; cycStart = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      if (!disturb || k >= len) cycStart = 1'b0;
      if (disturb && k == 1) begin
        divRatio = 4'($urandom_range(0, 15)); waitCnt = 3'($urandom_range(0, 7));
        shortEn = ~s; isRead = ~rd; suppress = ~sup;
      end
      #1;
      if (!csN) begin
        lowCnt++;
        if (sup || k > len || (sh && k < len - 1)) lowBad++;
      end
      if (capStb) begin capCnt++; capPos = k; end
      if (done) begin doneCnt++; donePos = k; end
    end
    cycStart = 1'b0;
    check(lowCnt == (sup ? 0 : (sh ? 2 : len)), req, "cs low clocks", lowCnt,
          sup ? 0 : (sh ? 2 : len));
    check(lowBad == 0, req, "cs low outside window", lowBad, 0);
    check(capCnt == (rd ? 1 : 0) && (!rd || capPos == len), "R6", "capture pos",
          capPos, rd ? len : 0);
    check(doneCnt == 1 && donePos == len + 1, "R7", "done pos", donePos, len + 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    check(csN == 1'b1 && capStb == 1'b0 && done == 1'b0, "R1", "reset outputs",
          {csN, capStb, done}, 3'b100);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1", "idle cs", csN, 1);

    runCycle(6, 0, 0, 1, 0, 0, "R2");   // 12 clocks normal
    runCycle(6, 0, 1, 1, 0, 0, "R3");   // 2 of 12
    runCycle(6, 1, 1, 0, 0, 0, "R3");   // 2 of 18
    runCycle(4, 0, 1, 1, 0, 0, "R3");
    runCycle(8, 7, 1, 1, 0, 0, "R3");
    runCycle(2, 1, 1, 1, 0, 0, "R4");   // short ignored
    runCycle(5, 0, 1, 0, 0, 0, "R4");
    runCycle(6, 0, 1, 1, 1, 0, "R5");
    runCycle(3, 2, 0, 0, 1, 0, "R5");
    runCycle(0, 0, 0, 1, 0, 0, "R10");  // 2 clocks
    runCycle(0, 3, 1, 1, 0, 0, "R10");
    runCycle(6, 1, 1, 1, 0, 1, "R8");   // start held high through cycle
    runCycle(4, 2, 0, 0, 0, 1, "R9");   // inputs scrambled mid-cycle

    for (int n = 0; n < 40; n++) begin
      int  d = $urandom_range(0, 15);
      int  w = $urandom_range(0, 7);
      bit  s = 1'($urandom_range(0, 1));
      bit  rd = 1'($urandom_range(0, 1));
      bit  sp = ($urandom_range(0, 5) == 0);
      bit  ds = ($urandom_range(0, 3) == 0);
      string tag;
      if (sp) tag = "R5";
      else if (expShort(s, d)) tag = "R3";
      else if (s) tag = "R4";
      else tag = "R2";
      runCycle(d, w, s, rd, sp, ds, tag);
    end
    repeat (2) @(negedge clk);
    check(csN == 1'b1, "R1", "idle cs after run", csN, 1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule